// File: doc/BRIEF.md
# Merging Store-Miss Queue

This block sits between a data cache that does not allocate lines on a write miss and the next level of memory. Stores that missed the cache are handed to it with a full-line data vector and a per-byte enable mask. The queue holds them so the core can continue while the writes reach the next level in the background. Each slot covers one line-sized, naturally aligned block of the address space. A store that lands in a block already held by a queued slot that is not currently being offered downstream joins that slot instead of taking a new one.

Slots leave in arrival order over a valid/ready handshake. The core is told to hold a store when every slot is in use and the store cannot join one. It is told to hold a load whose block is still queued, so a read never overtakes an older write. A flush request stops new stores and lets the queue empty, then reports completion. Cache maintenance and snoop handling use this before they finish.

Top module: `merge_wbuf`

## Requirements
- R1: While reset is held and right after it, the queue is empty: `dn_valid`, `st_stall`, `ld_stall` and `flush_done` are all low.
- R2: An accepted store whose block (address with its low log2(LINE_BYTES) bits cleared) matches no mergeable slot takes a new slot at the tail. The slot holds the store's bytes where `st_be` is set and zero bytes elsewhere.
- R3: An accepted store whose block matches a queued slot other than the head is merged into that slot. Its enabled bytes replace the old ones, its mask is ORed into the slot's mask, and no new slot is used.
- R4: The head slot is locked while it is offered on the drain port. A store to its block takes a new slot instead, and `dn_addr`, `dn_data` and `dn_be` stay stable until `dn_ready` is seen.
- R5: `dn_valid` is high whenever at least one slot is queued. Slots leave one per `dn_valid && dn_ready` cycle, in allocation order. `dn_addr` is the block address with its low offset bits zero, and `dn_data`/`dn_be` are the slot's bytes and mask. Byte i occupies data bits [8i+7:8i].
- R6: With DEPTH slots in use, `st_stall` is high for a valid store that cannot merge, and that store is not taken. A store that can merge while the queue is full is taken.
- R7: `ld_stall` is high exactly when `ld_valid` is high and the load's block matches any queued slot, including the head.
- R8: While `flush_req` is high, every valid store is stalled. `flush_done` is high exactly when `flush_req` is high and no slot is queued.
- R9: A drain and a store taken in the same cycle both take effect: the head leaves and the store allocates or merges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store-miss request |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | LINE_BYTES*8 | Store data at its byte lanes within the line |
| st_be | input | LINE_BYTES | Store byte enables |
| st_stall | output | 1 | Store must be held this cycle |
| ld_valid | input | 1 | Load request to be checked for hazards |
| ld_addr | input | ADDR_W | Load byte address |
| ld_stall | output | 1 | Load must wait for an older queued write |
| flush_req | input | 1 | Empty the queue and block new stores |
| flush_done | output | 1 | Flush requested and queue empty |
| dn_valid | output | 1 | Head slot offered downstream |
| dn_ready | input | 1 | Downstream accepts the head slot |
| dn_addr | output | ADDR_W | Block-aligned address of the head slot |
| dn_data | output | LINE_BYTES*8 | Head slot data |
| dn_be | output | LINE_BYTES | Head slot byte mask |

## Verification
The assertions check on every cycle that the head slot holds steady while backpressured, that occupancy never exceeds the depth and moves by at most one per cycle, that a store stalls outside a flush only when the queue is full, and that load hazards and flush completion agree with occupancy. Whether a merge writes the right bytes, whether a head-block store really allocates a new slot, and whether slots leave in order with the right contents can only be shown by the bench's scenarios. There, a queue model predicts every drained word.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      WR_NONE  = 2'd0,
      WR_ALLOC = 2'd1,
      WR_MERGE = 2'd2
   } wr_kind_e;
endpackage

// File: rtl/wbuf_entry.sv
module wbuf_entry
   import wbuf_pkg::*;
#(
   parameter int unsigned BLK_W      = 28,
   parameter int unsigned LINE_BYTES = 16,
   localparam int unsigned LINE_W    = LINE_BYTES * BYTE_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  wr_kind_e              kind,
   input  logic                  clr,
   input  logic [BLK_W-1:0]      in_blk,
   input  logic [LINE_W-1:0]     in_data,
   input  logic [LINE_BYTES-1:0] in_be,
   output logic                  vld,
   output logic [BLK_W-1:0]      blk,
   output logic [LINE_W-1:0]     data,
   output logic [LINE_BYTES-1:0] be
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld  <= 1'b0;
         blk  <= '0;
         data <= '0;
         be   <= '0;
      end else begin
         if (clr) vld <= 1'b0;
         if (kind == WR_ALLOC) begin
            vld <= 1'b1;
            blk <= in_blk;
            be  <= in_be;
            for (int i = 0; i < int'(LINE_BYTES); i++)
               data[i*BYTE_W +: BYTE_W] <= in_be[i] ? in_data[i*BYTE_W +: BYTE_W] : '0;
         end else if (kind == WR_MERGE) begin
            be <= be | in_be;
            for (int i = 0; i < int'(LINE_BYTES); i++)
               if (in_be[i]) data[i*BYTE_W +: BYTE_W] <= in_data[i*BYTE_W +: BYTE_W];
         end
      end
   end
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned BLK_W = 28,
   localparam int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0]            vld,
   input  logic [DEPTH-1:0][BLK_W-1:0] blk,
   input  logic [PTR_W-1:0]            head,
   input  logic [BLK_W-1:0]            st_blk,
   input  logic [BLK_W-1:0]            ld_blk,
   output logic                        mrg_hit,
   output logic [PTR_W-1:0]            mrg_idx,
   output logic                        ld_hit
);
   logic [DEPTH-1:0] cand;
   logic [DEPTH-1:0] ld_vec;

   for (genvar g = 0; g < int'(DEPTH); g++) begin : g_cmp
      assign cand[g]   = vld[g] && (PTR_W'(g) != head) && (blk[g] == st_blk);
      assign ld_vec[g] = vld[g] && (blk[g] == ld_blk);
   end

   always_comb begin
      mrg_idx = '0;
      for (int i = 0; i < int'(DEPTH); i++)
         if (cand[i]) mrg_idx = PTR_W'(i);
   end

   assign mrg_hit = |cand;
   assign ld_hit  = |ld_vec;
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf
   import wbuf_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_BYTES = 16,
   parameter int unsigned DEPTH      = 4,
   localparam int unsigned LINE_W    = LINE_BYTES * BYTE_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  st_valid,
   input  logic [ADDR_W-1:0]     st_addr,
   input  logic [LINE_W-1:0]     st_data,
   input  logic [LINE_BYTES-1:0] st_be,
   output logic                  st_stall,
   input  logic                  ld_valid,
   input  logic [ADDR_W-1:0]     ld_addr,
   output logic                  ld_stall,
   input  logic                  flush_req,
   output logic                  flush_done,
   output logic                  dn_valid,
   input  logic                  dn_ready,
   output logic [ADDR_W-1:0]     dn_addr,
   output logic [LINE_W-1:0]     dn_data,
   output logic [LINE_BYTES-1:0] dn_be
);
   localparam int unsigned OFS_W = $clog2(LINE_BYTES);
   localparam int unsigned BLK_W = ADDR_W - OFS_W;
   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("merge_wbuf: DEPTH must be a power of two, at least 2");
   end
   if (LINE_BYTES < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("merge_wbuf: LINE_BYTES must be a power of two, at least 2");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("merge_wbuf: ADDR_W too narrow for the line size");
   end

   logic [PTR_W-1:0] head, tail;
   logic [CNT_W-1:0] count;

   logic [DEPTH-1:0]                 e_vld;
   logic [DEPTH-1:0][BLK_W-1:0]      e_blk;
   logic [DEPTH-1:0][LINE_W-1:0]     e_data;
   logic [DEPTH-1:0][LINE_BYTES-1:0] e_be;
   wr_kind_e                         e_kind [DEPTH];

   logic [BLK_W-1:0] st_blk, ld_blk;
   logic             mrg_hit, ld_hit, full, st_take, do_alloc, do_merge, pop;
   logic [PTR_W-1:0] mrg_idx;

   assign st_blk = st_addr[ADDR_W-1:OFS_W];
   assign ld_blk = ld_addr[ADDR_W-1:OFS_W];

   wbuf_match #(.DEPTH(DEPTH), .BLK_W(BLK_W)) i_match (
      .vld(e_vld), .blk(e_blk), .head(head), .st_blk(st_blk), .ld_blk(ld_blk),
      .mrg_hit(mrg_hit), .mrg_idx(mrg_idx), .ld_hit(ld_hit)
   );

   assign full     = (count == CNT_W'(DEPTH));
   assign st_stall = st_valid && (flush_req || (full && !mrg_hit));
   assign st_take  = st_valid && !st_stall;
   assign do_merge = st_take && mrg_hit;
   assign do_alloc = st_take && !mrg_hit;

   assign dn_valid   = (count != '0);
   assign pop        = dn_valid && dn_ready;
   assign ld_stall   = ld_valid && ld_hit;
   assign flush_done = flush_req && !dn_valid;

   for (genvar g = 0; g < int'(DEPTH); g++) begin : g_slot
      assign e_kind[g] = (do_alloc && tail == PTR_W'(g))    ? WR_ALLOC :
                         (do_merge && mrg_idx == PTR_W'(g)) ? WR_MERGE : WR_NONE;
      wbuf_entry #(.BLK_W(BLK_W), .LINE_BYTES(LINE_BYTES)) i_entry (
         .clk(clk), .rst_n(rst_n), .kind(e_kind[g]),
         .clr(pop && head == PTR_W'(g)),
         .in_blk(st_blk), .in_data(st_data), .in_be(st_be),
         .vld(e_vld[g]), .blk(e_blk[g]), .data(e_data[g]), .be(e_be[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         if (pop)      head <= head + 1'b1;
         if (do_alloc) tail <= tail + 1'b1;
         count <= count + CNT_W'(do_alloc) - CNT_W'(pop);
      end
   end

   assign dn_addr = {e_blk[head], {OFS_W{1'b0}}};
   assign dn_data = e_data[head];
   assign dn_be   = e_be[head];
endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_BYTES = 16,
   parameter int unsigned DEPTH      = 4,
   localparam int unsigned LINE_W    = LINE_BYTES * 8,
   localparam int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  st_stall,
   input logic                  flush_req,
   input logic                  flush_done,
   input logic                  ld_stall,
   input logic                  dn_valid,
   input logic                  dn_ready,
   input logic [ADDR_W-1:0]     dn_addr,
   input logic [LINE_W-1:0]     dn_data,
   input logic [LINE_BYTES-1:0] dn_be,
   input logic [CNT_W-1:0]      occ
);
   a_r4_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_data) && $stable(dn_be)));

   a_r5_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occ) <= int'(DEPTH));

   a_r2_occ_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (int'(occ) <= int'($past(occ)) + 1) && (int'($past(occ)) <= int'(occ) + 1));

   a_r6_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (st_stall && !flush_req) |-> (int'(occ) == int'(DEPTH)));

   a_r7_hazard_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
      ld_stall |-> dn_valid);

   a_r8_done_means_empty: assert property (@(posedge clk) disable iff (!rst_n)
      flush_done |-> (!dn_valid && occ == '0));
endmodule

bind merge_wbuf wbuf_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .DEPTH(DEPTH)) i_chk (
   .clk(clk), .rst_n(rst_n), .st_stall(st_stall), .flush_req(flush_req),
   .flush_done(flush_done), .ld_stall(ld_stall), .dn_valid(dn_valid),
   .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_data(dn_data), .dn_be(dn_be),
   .occ(count)
);

// File: tb/test_merge_wbuf.sv
`timescale 1ns/1ps
module test_merge_wbuf;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         st_valid = 1'b0, ld_valid = 1'b0, flush_req = 1'b0, dn_ready = 1'b0;
   logic [31:0]  st_addr = '0, ld_addr = '0;
   logic [127:0] st_data = '0;
   logic [15:0]  st_be = '0;
   logic         st_stall, ld_stall, flush_done, dn_valid;
   logic [31:0]  dn_addr;
   logic [127:0] dn_data;
   logic [15:0]  dn_be;

   int total = 0, bad = 0;

   always #2.5 clk = ~clk;

   merge_wbuf i_merge_wbuf (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be), .st_stall(st_stall),
      .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_stall(ld_stall),
      .flush_req(flush_req), .flush_done(flush_done),
      .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_data(dn_data), .dn_be(dn_be)
   );

   // queue model: index 0 is the head
   logic [27:0]  m_blk [4];
   logic [127:0] m_dat [4];
   logic [15:0]  m_be  [4];
   int           m_n = 0;

   task automatic check(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", what, act, exp);
      end
   endtask

   task automatic step(input logic sv, input logic [31:0] sa, input logic [127:0] sd, input logic [15:0] sb,
                       input logic lv, input logic [31:0] la, input logic rdy, input logic fl, input string tag);
      int mj;
      bit lhit, exp_st, exp_dv, take;
      @(negedge clk);
      st_valid = sv; st_addr = sa; st_data = sd; st_be = sb;
      ld_valid = lv; ld_addr = la; dn_ready = rdy; flush_req = fl;
      #1;
      mj = -1;
      for (int j = 1; j < m_n; j++) if (m_blk[j] == sa[31:4]) mj = j;
      lhit = 1'b0;
      for (int j = 0; j < m_n; j++) if (m_blk[j] == la[31:4]) lhit = 1'b1;
      exp_st = sv && (fl || (m_n == 4 && mj < 0));
      exp_dv = (m_n != 0);
      check(st_stall === exp_st, {tag, " R6/R8 st_stall"}, 128'(st_stall), 128'(exp_st));
      check(ld_stall === (lv && lhit), {tag, " R7 ld_stall"}, 128'(ld_stall), 128'(lv && lhit));
      check(flush_done === (fl && m_n == 0), {tag, " R8 flush_done"}, 128'(flush_done), 128'(fl && m_n == 0));
      check(dn_valid === exp_dv, {tag, " R5 dn_valid"}, 128'(dn_valid), 128'(exp_dv));
      if (exp_dv) begin
         check(dn_addr === {m_blk[0], 4'h0}, {tag, " R5/R2 dn_addr"}, 128'(dn_addr), 128'({m_blk[0], 4'h0}));
         check(dn_be === m_be[0], {tag, " R5/R3 dn_be"}, 128'(dn_be), 128'(m_be[0]));
         check(dn_data === m_dat[0], {tag, " R5/R3 dn_data"}, dn_data, m_dat[0]);
      end
      take = sv && !exp_st;
      if (take && mj >= 0) begin
         m_be[mj] = m_be[mj] | sb;
         for (int b = 0; b < 16; b++) if (sb[b]) m_dat[mj][b*8 +: 8] = sd[b*8 +: 8];
      end
      if (exp_dv && rdy) begin
         for (int j = 0; j < 3; j++) begin
            m_blk[j] = m_blk[j+1]; m_dat[j] = m_dat[j+1]; m_be[j] = m_be[j+1];
         end
         m_n--;
      end
      if (take && mj < 0) begin
         m_blk[m_n] = sa[31:4];
         m_be[m_n]  = sb;
         for (int b = 0; b < 16; b++) m_dat[m_n][b*8 +: 8] = sb[b] ? sd[b*8 +: 8] : 8'h00;
         m_n++;
      end
   endtask

   function automatic logic [127:0] pat(input logic [7:0] k);
      logic [127:0] r;
      for (int b = 0; b < 16; b++) r[b*8 +: 8] = k + 8'(b * 17);
      return r;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired act=%h exp=%h", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] lf;
      repeat (3) @(posedge clk);
      @(negedge clk);
      st_valid = 1'b1;
      #1;
      check(!dn_valid && !st_stall && !ld_stall && !flush_done, "R1 reset state", 128'({dn_valid, st_stall, ld_stall, flush_done}), 128'(0));
      st_valid = 1'b0;
      rst_n = 1'b1;

      // R2 allocation into distinct blocks
      step(1, 32'h0000_0010, pat(8'h10), 16'h000F, 0, 0, 0, 0, "R2 alloc blk1");
      step(1, 32'h0000_0024, pat(8'h20), 16'h00F0, 0, 0, 0, 0, "R2 alloc blk2");
      // R3 merge into non-head slot
      step(1, 32'h0000_0028, pat(8'h30), 16'h0F30, 0, 0, 0, 0, "R3 merge blk2");
      // R4 head locked: same block as head takes new slot
      step(1, 32'h0000_0018, pat(8'h40), 16'hF000, 0, 0, 0, 0, "R4 head block new slot");
      step(1, 32'h0000_0030, pat(8'h50), 16'hFFFF, 0, 0, 0, 0, "R2 alloc blk3 fills");
      // R6 full and non-mergeable stalls; mergeable accepted
      step(1, 32'h0000_0050, pat(8'h60), 16'h0001, 0, 0, 0, 0, "R6 full stall");
      step(1, 32'h0000_0034, pat(8'h70), 16'h0100, 0, 0, 0, 0, "R6 merge while full");
      step(1, 32'h0000_0010, pat(8'h80), 16'h0002, 0, 0, 0, 0, "R6 merge into tail-side blk1");
      // R7 load hazards
      step(0, 0, 0, 0, 1, 32'h0000_001C, 0, 0, "R7 load hits head");
      step(0, 0, 0, 0, 1, 32'h0000_0038, 0, 0, "R7 load hits tail");
      step(0, 0, 0, 0, 1, 32'h0000_0090, 0, 0, "R7 load misses");
      // R4 hold under backpressure then R9 drain with store in same cycle
      step(0, 0, 0, 0, 0, 0, 0, 0, "R4 hold");
      step(1, 32'h0000_0070, pat(8'h90), 16'h00FF, 0, 0, 1, 0, "R9 drain and store (full stall)");
      step(1, 32'h0000_0070, pat(8'h90), 16'h00FF, 0, 0, 1, 0, "R9 drain and alloc");
      step(1, 32'h0000_0074, pat(8'hA0), 16'hFF00, 0, 0, 1, 0, "R9 drain and merge");
      // R8 flush with store attempts
      for (int k = 0; k < 8; k++)
         step(1, 32'h0000_0100, pat(8'hB0), 16'h0001, 0, 0, 1, 1, "R8 flush");
      step(0, 0, 0, 0, 0, 0, 0, 0, "R8 flush released");

      // sweep over a small set of blocks
      lf = 32'hACE1_2345;
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] a, la2;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         a   = {24'h0, 4'(lf[7:5] % 3'd6), lf[3:0]} + 32'h200;
         la2 = {24'h0, 4'(lf[12:10] % 3'd6), lf[3:0]} + 32'h200;
         step(lf[13] | lf[14], a, pat(lf[23:16]), lf[31:16], lf[15], la2,
              lf[24] & lf[25], (lf[29:26] == 4'h0), "R5 sweep");
      end
      for (int k = 0; k < 6; k++)
         step(0, 0, 0, 0, 0, 0, 1, 1, "R8 final flush");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule